// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides, for each cache-block instruction (zero a block, clean a block, flush a block, invalidate a block), whether the operation may go ahead or must trap. It combines three inputs. The first is the hart's current privilege and virtualization state. The second is the per-operation enable bits held in three levels of environment-configuration state: machine, hypervisor and supervisor. The third is the read and write permission verdicts that an external translation and protection unit returns for the target block.

The configuration checks are applied in a fixed priority, and the first one that fails decides the trap. The address is aligned down to the relevant block size. The block size is a power of two, with one size for zeroing and another for the maintenance operations. For a zero operation the access check needs write permission. For the maintenance operations it accepts either read or write permission.

The checks are combinational. The verdict is registered once and returned one cycle after the request, with a valid strobe. The verdict holds the aligned address, a grant, a one-hot cause vector, and a flag that marks a store fault as the guest-page variant.

Top module: `cbo_permit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_grant`, `rsp_cause` and `rsp_guest` are all zero.
- R2: `req_op` encodes 0 = zero, 1 = clean, 2 = flush, 3 = invalidate. Each configuration input uses bit 0 as the zero enable, bit 1 as the enable that clean and flush share, and bit 2 as the invalidate enable. Only the bit that belongs to the requested operation is consulted.
- R3: `req_priv` encodes U = 0, S = 1, M = 3. If the privilege is below M and the operation's bit in `m_cfg` is clear, the cause is illegal instruction, whatever the other inputs are.
- R4: If R3 does not apply and `req_virt` is high, the cause is virtual instruction when either of two conditions holds: the privilege is S or lower and the `h_cfg` bit is clear, or the privilege is U and the `s_cfg` bit is clear.
- R5: If neither R3 nor R4 applies, the privilege is U and the `s_cfg` bit is clear, the cause is illegal instruction.
- R6: At privilege M no configuration bit has any effect, but the access-permission check still applies.
- R7: `rsp_addr` is `req_addr` with its low bits cleared. A zero operation clears log2(`ZERO_BLK_BYTES`) bits. The other operations clear log2(`MGMT_BLK_BYTES`) bits.
- R8: A zero operation that passes the configuration checks is granted only if `perm_wr` is high. Otherwise the cause is store fault.
- R9: A clean, flush or invalidate operation that passes the configuration checks is granted if `perm_rd` is high, or if `perm_rd` is low and `perm_wr` is high. Otherwise the cause is store fault, and `rsp_guest` is high exactly when `req_virt` was high.
- R10: `rsp_cause` is one-hot or zero, with bit 0 = illegal instruction, bit 1 = virtual instruction and bit 2 = store fault. `rsp_grant` is high exactly when the cause is zero on a valid response. A configuration trap suppresses any store fault.
- R11: `rsp_valid` is `req_valid` delayed by one clock, and the verdict fields belong to that request. When `rsp_valid` is low, `rsp_grant`, `rsp_cause` and `rsp_guest` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (R2) |
| req_priv | input | 2 | Current privilege (R3) |
| req_virt | input | 1 | Virtualization active |
| req_addr | input | AW | Target byte address |
| m_cfg | input | 3 | Machine-level operation enables |
| h_cfg | input | 3 | Hypervisor-level operation enables |
| s_cfg | input | 3 | Supervisor-level operation enables |
| perm_rd | input | 1 | Target block is readable |
| perm_wr | input | 1 | Target block is writable |
| rsp_valid | output | 1 | Verdict valid |
| rsp_addr | output | AW | Block-aligned address |
| rsp_grant | output | 1 | Operation may proceed |
| rsp_cause | output | 3 | One-hot trap cause |
| rsp_guest | output | 1 | Store fault is the guest-page variant |

## Verification
A configuration trap and an access-permission failure can both apply to the same request. So can the virtual-instruction and supervisor-illegal conditions. The bench provokes the first collision by clearing an enable while also withholding both permissions. It then expects the configuration cause alone, with no store-fault bit and no guest flag. It provokes the second collision with virtualization on and both the hypervisor and supervisor enables clear, and expects only the virtual-instruction cause. The bench also runs back-to-back requests with different operations. This checks that each verdict and its alignment match the request made one cycle earlier.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_INVAL = 2'd3
    } op_e;

    localparam int CFG_W       = 3;
    localparam int EN_ZERO_IDX = 0;
    localparam int EN_CF_IDX   = 1;
    localparam int EN_INV_IDX  = 2;

    localparam int CAUSE_W     = 3;
    localparam int CAUSE_ILL   = 0;
    localparam int CAUSE_VIRT  = 1;
    localparam int CAUSE_STORE = 2;

    typedef struct packed {
        logic                grant;
        logic [CAUSE_W-1:0]  cause;
        logic                guest;
    } verdict_t;

    function automatic int unsigned en_index(input logic [1:0] op);
        case (op)
            OP_ZERO:  return EN_ZERO_IDX;
            OP_INVAL: return EN_INV_IDX;
            default:  return EN_CF_IDX;
        endcase
    endfunction

    function automatic logic is_zero_op(input logic [1:0] op);
        return op == OP_ZERO;
    endfunction

endpackage

// File: rtl/cbo_cfg_gate.sv
module cbo_cfg_gate
    import cbo_pkg::*;
(
    input  logic [1:0]       op,
    input  logic [1:0]       priv,
    input  logic             virt,
    input  logic [CFG_W-1:0] m_cfg,
    input  logic [CFG_W-1:0] h_cfg,
    input  logic [CFG_W-1:0] s_cfg,
    output logic             trap_ill,
    output logic             trap_virt
);
    logic m_en, h_en, s_en;
    logic below_m, at_or_below_s, below_s;
    logic m_fail, v_fail, s_fail;

    always_comb begin
        m_en = m_cfg[en_index(op)];
        h_en = h_cfg[en_index(op)];
        s_en = s_cfg[en_index(op)];

        below_m       = (priv != PRIV_M);
        at_or_below_s = (priv == PRIV_U) || (priv == PRIV_S);
        below_s       = (priv == PRIV_U);

        // Fixed priority: machine level, then virtual, then supervisor level.
        m_fail = below_m && !m_en;
        v_fail = virt && ((at_or_below_s && !h_en) || (below_s && !s_en));
        s_fail = below_s && !s_en;

        trap_ill  = m_fail || (!v_fail && s_fail);
        trap_virt = !m_fail && v_fail;
    end
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
    import cbo_pkg::*;
(
    input  logic [1:0] op,
    input  logic       virt,
    input  logic       perm_rd,
    input  logic       perm_wr,
    output logic       store_fault,
    output logic       guest
);
    always_comb begin
        if (is_zero_op(op)) begin
            store_fault = !perm_wr;
        end else begin
            // Readable suffices; otherwise fall back to a write check.
            store_fault = !perm_rd && !perm_wr;
        end
        guest = store_fault && virt;
    end
endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    localparam int LSB = $clog2(BLK_BYTES);

    generate
        if (LSB == 0) begin : g_pass
            assign addr_out = addr_in;
        end else begin : g_mask
            assign addr_out = {addr_in[AW-1:LSB], {LSB{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/cbo_permit.sv
module cbo_permit
    import cbo_pkg::*;
#(
    parameter int AW             = 32,
    parameter int ZERO_BLK_BYTES = 64,
    parameter int MGMT_BLK_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_priv,
    input  logic          req_virt,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    m_cfg,
    input  logic [2:0]    h_cfg,
    input  logic [2:0]    s_cfg,
    input  logic          perm_rd,
    input  logic          perm_wr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_grant,
    output logic [2:0]    rsp_cause,
    output logic          rsp_guest
);
    localparam logic [AW-1:0] ZERO_MASK = AW'(ZERO_BLK_BYTES - 1);
    localparam logic [AW-1:0] MGMT_MASK = AW'(MGMT_BLK_BYTES - 1);

    logic          trap_ill, trap_virt;
    logic          st_fault, st_guest;
    logic [AW-1:0] addr_zero, addr_mgmt, addr_sel;
    verdict_t      vd_next, vd_q;

    cbo_cfg_gate u_gate (
        .op        (req_op),
        .priv      (req_priv),
        .virt      (req_virt),
        .m_cfg     (m_cfg),
        .h_cfg     (h_cfg),
        .s_cfg     (s_cfg),
        .trap_ill  (trap_ill),
        .trap_virt (trap_virt)
    );

    cbo_perm_check u_perm (
        .op          (req_op),
        .virt        (req_virt),
        .perm_rd     (perm_rd),
        .perm_wr     (perm_wr),
        .store_fault (st_fault),
        .guest       (st_guest)
    );

    cbo_align #(.AW(AW), .BLK_BYTES(ZERO_BLK_BYTES)) u_align_zero (
        .addr_in  (req_addr),
        .addr_out (addr_zero)
    );

    cbo_align #(.AW(AW), .BLK_BYTES(MGMT_BLK_BYTES)) u_align_mgmt (
        .addr_in  (req_addr),
        .addr_out (addr_mgmt)
    );

    always_comb begin
        addr_sel = is_zero_op(req_op) ? addr_zero : addr_mgmt;
        vd_next  = '0;
        if (req_valid) begin
            if (trap_ill) begin
                vd_next.cause[CAUSE_ILL] = 1'b1;
            end else if (trap_virt) begin
                vd_next.cause[CAUSE_VIRT] = 1'b1;
            end else if (st_fault) begin
                vd_next.cause[CAUSE_STORE] = 1'b1;
                vd_next.guest              = st_guest;
            end else begin
                vd_next.grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            vd_q      <= '0;
        end else begin
            rsp_valid <= req_valid;
            vd_q      <= vd_next;
            if (req_valid) begin
                rsp_addr <= addr_sel;
            end
        end
    end

    assign rsp_grant = vd_q.grant;
    assign rsp_cause = vd_q.cause;
    assign rsp_guest = vd_q.guest;

    // Assertions
    p_cause_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_cause));

    p_grant_excl_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_grant |-> (rsp_valid && rsp_cause == '0));

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_grant && rsp_cause == '0));

    p_mmode_nocfg_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == PRIV_M) |=> (!rsp_cause[CAUSE_ILL] && !rsp_cause[CAUSE_VIRT]));

    p_zero_align_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_ZERO) |=> ((rsp_addr & ZERO_MASK) == '0));

    p_mgmt_align_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != OP_ZERO) |=> ((rsp_addr & MGMT_MASK) == '0));

    p_guest_store_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_guest |-> rsp_cause[CAUSE_STORE]);

    p_mgmt_rd_grant_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == PRIV_M && req_op != OP_ZERO && perm_rd) |=> rsp_grant);
endmodule

// File: tb/cbo_permit_bench.sv
module cbo_permit_bench;
    localparam int AW = 32;
    localparam int ZB = 64;
    localparam int MB = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [1:0]    req_priv;
    logic          req_virt;
    logic [AW-1:0] req_addr;
    logic [2:0]    m_cfg, h_cfg, s_cfg;
    logic          perm_rd, perm_wr;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic          rsp_grant;
    logic [2:0]    rsp_cause;
    logic          rsp_guest;

    int checks   = 0;
    int failures = 0;

    localparam logic [2:0] C_NONE  = 3'b000;
    localparam logic [2:0] C_ILL   = 3'b001;
    localparam logic [2:0] C_VIRT  = 3'b010;
    localparam logic [2:0] C_STORE = 3'b100;

    always #5 clk = ~clk;

    cbo_permit #(.AW(AW), .ZERO_BLK_BYTES(ZB), .MGMT_BLK_BYTES(MB)) u_cbo_permit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_priv(req_priv), .req_virt(req_virt), .req_addr(req_addr),
        .m_cfg(m_cfg), .h_cfg(h_cfg), .s_cfg(s_cfg),
        .perm_rd(perm_rd), .perm_wr(perm_wr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_grant(rsp_grant),
        .rsp_cause(rsp_cause), .rsp_guest(rsp_guest)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Drive one request at a falling edge; result is visible one falling edge later.
    task automatic issue(input logic [1:0] op, input logic [1:0] priv, input logic virt,
                         input logic [AW-1:0] addr, input logic [2:0] m, input logic [2:0] h,
                         input logic [2:0] s, input logic rd, input logic wr);
        req_valid = 1'b1; req_op = op; req_priv = priv; req_virt = virt; req_addr = addr;
        m_cfg = m; h_cfg = h; s_cfg = s; perm_rd = rd; perm_wr = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic grant, input logic [2:0] cause,
                              input logic guest);
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " grant"}, 64'(rsp_grant), 64'(grant));
        chk({req, " cause"}, 64'(rsp_cause), 64'(cause));
        chk({req, " guest"}, 64'(rsp_guest), 64'(guest));
    endtask

    task automatic t_reset;
        chk("R1 valid", 64'(rsp_valid), 64'd0);
        chk("R1 grant", 64'(rsp_grant), 64'd0);
        chk("R1 cause", 64'(rsp_cause), 64'd0);
        chk("R1 guest", 64'(rsp_guest), 64'd0);
    endtask

    task automatic t_enable_map;
        // R2: only the op's own bit matters; S-mode, no virt, other bits set.
        issue(2'd0, 2'd1, 1'b0, 32'h100, 3'b110, 3'b111, 3'b111, 1'b1, 1'b1);
        expect_rsp("R2 zero uses bit0", 1'b0, C_ILL, 1'b0);
        issue(2'd1, 2'd1, 1'b0, 32'h100, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1);
        expect_rsp("R2 clean uses bit1", 1'b0, C_ILL, 1'b0);
        issue(2'd2, 2'd1, 1'b0, 32'h100, 3'b010, 3'b111, 3'b111, 1'b1, 1'b1);
        expect_rsp("R2 flush uses bit1", 1'b1, C_NONE, 1'b0);
        issue(2'd3, 2'd1, 1'b0, 32'h100, 3'b011, 3'b111, 3'b111, 1'b1, 1'b1);
        expect_rsp("R2 inval uses bit2", 1'b0, C_ILL, 1'b0);
    endtask

    task automatic t_mlevel;
        // R3: machine enable clear beats virt and supervisor conditions.
        issue(2'd3, 2'd0, 1'b1, 32'h0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b1);
        expect_rsp("R3 m-level top priority", 1'b0, C_ILL, 1'b0);
    endtask

    task automatic t_virtual;
        // R4: S-mode virtualized, hypervisor enable clear.
        issue(2'd1, 2'd1, 1'b1, 32'h0, 3'b111, 3'b000, 3'b111, 1'b1, 1'b1);
        expect_rsp("R4 s-mode h clear", 1'b0, C_VIRT, 1'b0);
        // R4: U-mode virtualized, supervisor enable clear only.
        issue(2'd1, 2'd0, 1'b1, 32'h0, 3'b111, 3'b111, 3'b000, 1'b1, 1'b1);
        expect_rsp("R4 u-mode s clear", 1'b0, C_VIRT, 1'b0);
        // R4: S-mode virtualized with s clear only -> granted.
        issue(2'd1, 2'd1, 1'b1, 32'h0, 3'b111, 3'b111, 3'b000, 1'b1, 1'b1);
        expect_rsp("R4 s-mode ignores s_cfg", 1'b1, C_NONE, 1'b0);
        // R4 collision with R5 conditions: virtual wins.
        issue(2'd0, 2'd0, 1'b1, 32'h0, 3'b111, 3'b000, 3'b000, 1'b1, 1'b1);
        expect_rsp("R4 beats R5", 1'b0, C_VIRT, 1'b0);
    endtask

    task automatic t_slevel;
        issue(2'd0, 2'd0, 1'b0, 32'h0, 3'b111, 3'b000, 3'b110, 1'b1, 1'b1);
        expect_rsp("R5 u-mode s clear", 1'b0, C_ILL, 1'b0);
        issue(2'd0, 2'd0, 1'b0, 32'h0, 3'b111, 3'b000, 3'b111, 1'b1, 1'b1);
        expect_rsp("R5 u-mode s set h ignored", 1'b1, C_NONE, 1'b0);
    endtask

    task automatic t_mmode;
        issue(2'd3, 2'd3, 1'b0, 32'h0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b1);
        expect_rsp("R6 m-mode cfg bypass", 1'b1, C_NONE, 1'b0);
        issue(2'd0, 2'd3, 1'b0, 32'h0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b0);
        expect_rsp("R6 m-mode perm kept", 1'b0, C_STORE, 1'b0);
    endtask

    task automatic t_align;
        issue(2'd0, 2'd3, 1'b0, 32'hDEAD_BEFF, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1);
        chk("R7 zero align", 64'(rsp_addr), 64'h0000_0000_DEAD_BEC0);
        issue(2'd2, 2'd3, 1'b0, 32'hDEAD_BEFF, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1);
        chk("R7 mgmt align", 64'(rsp_addr), 64'h0000_0000_DEAD_BEE0);
        // Back to back: each response tracks its own request.
        req_valid = 1'b1; req_op = 2'd0; req_priv = 2'd3; req_virt = 1'b0;
        req_addr = 32'h0000_0071; perm_rd = 1'b1; perm_wr = 1'b0;
        @(negedge clk);
        chk("R11 b2b first verdict", 64'({rsp_grant, rsp_cause}), 64'({1'b0, C_STORE}));
        chk("R7 b2b first addr", 64'(rsp_addr), 64'h40);
        req_op = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 b2b second verdict", 64'({rsp_grant, rsp_cause}), 64'({1'b1, C_NONE}));
        chk("R7 b2b second addr", 64'(rsp_addr), 64'h60);
    endtask

    task automatic t_zero_perm;
        issue(2'd0, 2'd1, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b1);
        expect_rsp("R8 zero write only", 1'b1, C_NONE, 1'b0);
        issue(2'd0, 2'd1, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b0);
        expect_rsp("R8 zero read not enough", 1'b0, C_STORE, 1'b0);
    endtask

    task automatic t_mgmt_perm;
        issue(2'd3, 2'd1, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b0);
        expect_rsp("R9 read only", 1'b1, C_NONE, 1'b0);
        issue(2'd1, 2'd1, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b1);
        expect_rsp("R9 write fallback", 1'b1, C_NONE, 1'b0);
        issue(2'd2, 2'd1, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0);
        expect_rsp("R9 no perm", 1'b0, C_STORE, 1'b0);
        issue(2'd2, 2'd1, 1'b1, 32'h0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0);
        expect_rsp("R9 no perm guest", 1'b0, C_STORE, 1'b1);
    endtask

    task automatic t_collision;
        // R10: config trap suppresses store fault and guest flag.
        issue(2'd3, 2'd1, 1'b1, 32'h0, 3'b111, 3'b011, 3'b111, 1'b0, 1'b0);
        expect_rsp("R10 virt over store", 1'b0, C_VIRT, 1'b0);
        issue(2'd0, 2'd0, 1'b0, 32'h0, 3'b110, 3'b111, 3'b111, 1'b0, 1'b0);
        expect_rsp("R10 ill over store", 1'b0, C_ILL, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R11 idle valid", 64'(rsp_valid), 64'd0);
        chk("R11 idle verdict", 64'({rsp_grant, rsp_cause, rsp_guest}), 64'd0);
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_priv = '0; req_virt = 1'b0;
        req_addr = '0; m_cfg = '0; h_cfg = '0; s_cfg = '0; perm_rd = 1'b0; perm_wr = 1'b0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_enable_map;
        t_mlevel;
        t_virtual;
        t_slevel;
        t_mmode;
        t_align;
        t_zero_perm;
        t_mgmt_perm;
        t_collision;
        t_idle;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule